// File: doc/BRIEF.md
# Oscillator Halt Detector and Control Registers

This block keeps the control state that sits beside a serial real-time clock's counters. It holds two 4-bit control registers and a one-bit clock-output register. It also watches the slow 32.768 kHz crystal oscillator, which arrives as an asynchronous input and is sampled by a fast system clock. When no oscillator edge arrives for a programmable number of system clocks while chip-enable is low, the block sets a sticky halt flag. A set halt flag forces the clock output on, so that a host sees straight away that the clock data can no longer be trusted.

The serial framing logic in front of this block supplies a decoded write strobe with a 4-bit address and data, plus a read address. The block answers that read address at once with the register contents. The counters behind it receive the carry-enable level and a one-cycle adjust request, and they report their busy state back to the block. The clock output is an open-drain model: an enable that pulls the pin low while the oscillator phase is low, and a level output that is always 0.

Top module: `osc_ctrl_regs`

## Requirements
- R1: A read of address 0xE returns D3=0, D2=0, D1=halt flag and D0=the busy_in input.
- R2: Address 0xF holds D3 as the 12/24 select (1 = 24-hour), D1 as the bank select and D0 as the test bit (1 = normal operation). D2 always reads 0. After reset the register reads 0001.
- R3: While chip_en is low, carry_en and the test bit are forced to 1 from the next system clock on.
- R4: The halt flag is 1 after reset. It is set when chip_en is low and no oscillator edge has been seen for HALT_CYCLES system clocks. While chip_en is high it keeps its value.
- R5: A set halt flag stays set after the oscillator restarts. It clears only on a write to 0xE made while the oscillator is running (an edge within the last HALT_CYCLES clocks).
- R6: The clock-output bit is D0 of address 0xA and is reachable only while the bank bit is 1 (0 = output running, 1 = released). With bank 0, writes to 0xA are ignored and reads of 0xA return 0. The bit is 0 after reset.
- R7: While the halt flag is set, the clock-output bit is held at 0 and writes of 1 to it are ignored.
- R8: A change of the clock-output bit is applied at a rising oscillator edge: the second one for enable, the first one for disable. While the output is on, clkout_oe is 1 exactly while the synchronized oscillator is low. clkout_lvl is always 0.
- R9: Writing D0=1 to 0xE makes a one-cycle adj_req pulse. If carry_en is 0, the pulse waits until carry_en is 1.
- R10: wr_en has no effect while chip_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_in | input | 1 | Asynchronous slow oscillator |
| chip_en | input | 1 | Chip-enable level of the serial port |
| wr_en | input | 1 | Decoded register write strobe, one cycle |
| wr_addr | input | 4 | Write address |
| wr_data | input | 4 | Write data, D3..D0 |
| rd_addr | input | 4 | Read address |
| rd_data | output | 4 | Read data for rd_addr, combinational |
| busy_in | input | 1 | Counter busy status |
| carry_en | output | 1 | Seconds carry enable to the counters |
| adj_req | output | 1 | One-cycle 30-second adjust request |
| hour24 | output | 1 | 1 selects 24-hour display |
| bank_sel | output | 1 | Bank select bit |
| test_n | output | 1 | Test bit, 1 means normal operation |
| clkout_oe | output | 1 | Open-drain pull-low enable of the clock output |
| clkout_lvl | output | 1 | Driven level of the clock output, constant 0 |

## Verification
The assertions assume that the framing logic raises wr_en only as a one-cycle strobe, that osc_in changes slowly compared with HALT_CYCLES, and that reset is applied before any use. The bench meets these assumptions. It toggles the oscillator every eight system clocks, which stays far below the default limit of 64. It stops the oscillator only by freezing its level. It drives every strobe for exactly one cycle, between falling edges. To reach each halt condition, the bench combines the oscillator state (running or frozen) with the chip-enable level.

// File: rtl/osc_ctrl_pkg.sv
package osc_ctrl_pkg;
   localparam int ADDR_W = 4;
   localparam int DATA_W = 4;
   typedef logic [ADDR_W-1:0] addr_t;
   typedef logic [DATA_W-1:0] nib_t;
   localparam addr_t A_CTRL1 = 4'hE;
   localparam addr_t A_CTRL2 = 4'hF;
   localparam addr_t A_CLKO  = 4'hA;
endpackage

// File: rtl/osc_sync.sv
module osc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic level,
   output logic any_edge,
   output logic rise
);
   logic [STAGES:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("osc_sync needs at least two stages");
      end
      for (genvar i = 0; i <= STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else if (i == 0) chain[i] <= async_in;
            else chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign level    = chain[STAGES-1];
   assign any_edge = chain[STAGES-1] ^ chain[STAGES];
   assign rise     = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/osc_halt_det.sv
module osc_halt_det #(
   parameter int HALT_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_edge,
   input  logic chip_en,
   input  logic clr_req,
   output logic stalled,
   output logic halt
);
   localparam int CNT_W = $clog2(HALT_CYCLES + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HALT_CYCLES);

   logic [CNT_W-1:0] idle_cnt;
   logic             halt_q;

   generate
      if (HALT_CYCLES < 2) begin : g_bad
         $error("HALT_CYCLES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idle_cnt <= '0;
      else if (osc_edge) idle_cnt <= '0;
      else if (idle_cnt != LIMIT) idle_cnt <= idle_cnt + 1'b1;
   end

   assign stalled = (idle_cnt == LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) halt_q <= 1'b1;
      else if (!chip_en && stalled) halt_q <= 1'b1;
      else if (clr_req && !stalled) halt_q <= 1'b0;
   end

   assign halt = halt_q;
endmodule

// File: rtl/osc_clkout_gate.sv
module osc_clkout_gate #(
   parameter int ON_EDGES  = 2,
   parameter int OFF_EDGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic want_on,
   input  logic osc_rise,
   input  logic osc_level,
   output logic gate_on,
   output logic pull_low
);
   localparam int MAXE  = (ON_EDGES > OFF_EDGES) ? ON_EDGES : OFF_EDGES;
   localparam int ECW   = $clog2(MAXE + 1);

   logic [ECW-1:0] edge_cnt;
   logic [ECW-1:0] need;
   logic           on_q;

   generate
      if (ON_EDGES < 1 || OFF_EDGES < 1) begin : g_bad
         $error("edge counts must be at least 1");
      end
   endgenerate

   assign need = want_on ? ECW'(ON_EDGES) : ECW'(OFF_EDGES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q     <= 1'b1;
         edge_cnt <= '0;
      end else if (want_on == on_q) begin
         edge_cnt <= '0;
      end else if (osc_rise) begin
         if (edge_cnt + 1'b1 == need) begin
            on_q     <= want_on;
            edge_cnt <= '0;
         end else begin
            edge_cnt <= edge_cnt + 1'b1;
         end
      end
   end

   assign gate_on  = on_q;
   assign pull_low = on_q & ~osc_level;
endmodule

// File: rtl/osc_ctrl_regs.sv
module osc_ctrl_regs
   import osc_ctrl_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int HALT_CYCLES = 64,
   parameter int ON_EDGES    = 2,
   parameter int OFF_EDGES   = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       osc_in,
   input  logic       chip_en,
   input  logic       wr_en,
   input  logic [3:0] wr_addr,
   input  logic [3:0] wr_data,
   input  logic [3:0] rd_addr,
   output logic [3:0] rd_data,
   input  logic       busy_in,
   output logic       carry_en,
   output logic       adj_req,
   output logic       hour24,
   output logic       bank_sel,
   output logic       test_n,
   output logic       clkout_oe,
   output logic       clkout_lvl
);
   logic osc_lvl, osc_any, osc_rise;
   logic stalled, halt_q;
   logic wr_ok, wr_c1, wr_c2, wr_co;
   logic carry_q, adj_pend, h24_q, bank_q, test_q, clen_q;
   logic gate_on;

   assign wr_ok = wr_en & chip_en;
   assign wr_c1 = wr_ok && (wr_addr == A_CTRL1);
   assign wr_c2 = wr_ok && (wr_addr == A_CTRL2);
   assign wr_co = wr_ok && (wr_addr == A_CLKO) && bank_q;

   osc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(osc_in),
      .level(osc_lvl), .any_edge(osc_any), .rise(osc_rise)
   );

   osc_halt_det #(.HALT_CYCLES(HALT_CYCLES)) u_halt (
      .clk(clk), .rst_n(rst_n), .osc_edge(osc_any), .chip_en(chip_en),
      .clr_req(wr_c1), .stalled(stalled), .halt(halt_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         carry_q  <= 1'b1;
         adj_pend <= 1'b0;
         h24_q    <= 1'b0;
         bank_q   <= 1'b0;
         test_q   <= 1'b1;
         clen_q   <= 1'b0;
      end else begin
         if (!chip_en) carry_q <= 1'b1;
         else if (wr_c1) carry_q <= wr_data[1];

         adj_pend <= (adj_pend & ~carry_q) | (wr_c1 & wr_data[0]);

         if (wr_c2) begin
            h24_q  <= wr_data[3];
            bank_q <= wr_data[1];
         end

         if (!chip_en) test_q <= 1'b1;
         else if (wr_c2) test_q <= wr_data[0];

         if (halt_q) clen_q <= 1'b0;
         else if (wr_co) clen_q <= wr_data[0];
      end
   end

   osc_clkout_gate #(.ON_EDGES(ON_EDGES), .OFF_EDGES(OFF_EDGES)) u_gate (
      .clk(clk), .rst_n(rst_n), .want_on(~clen_q), .osc_rise(osc_rise),
      .osc_level(osc_lvl), .gate_on(gate_on), .pull_low(clkout_oe)
   );

   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         A_CTRL1: rd_data = {2'b00, halt_q, busy_in};
         A_CTRL2: rd_data = {h24_q, 1'b0, bank_q, test_q};
         A_CLKO:  rd_data = bank_q ? {3'b000, clen_q} : 4'b0000;
         default: rd_data = '0;
      endcase
   end

   assign carry_en   = carry_q;
   assign adj_req    = adj_pend & carry_q;
   assign hour24     = h24_q;
   assign bank_sel   = bank_q;
   assign test_n     = test_q;
   assign clkout_lvl = 1'b0;
endmodule

// File: rtl/osc_ctrl_chk.sv
module osc_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       chip_en,
   input logic       wr_en,
   input logic [3:0] wr_addr,
   input logic [3:0] rd_addr,
   input logic [3:0] rd_data,
   input logic       busy_in,
   input logic       carry_en,
   input logic       test_n,
   input logic       adj_req,
   input logic       halt_q,
   input logic       clen_q,
   input logic       gate_on,
   input logic       osc_rise,
   input logic       clkout_lvl
);
   always_comb begin
      if (rst_n && rd_addr == 4'hE)
         assert_ctrl1_fmt_R1: assert (rd_data[3:2] == 2'b00 && rd_data[0] == busy_in);
   end

   assert_force_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_en |=> (carry_en && test_n));

   assert_halt_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt_q) |-> $past(!chip_en));

   assert_halt_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(halt_q) |-> $past(wr_en && chip_en && wr_addr == 4'hE));

   assert_halt_forces_R7: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q |=> !clen_q);

   assert_gate_at_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(gate_on) |-> $past(osc_rise));

   assert_level_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clkout_lvl == 1'b0);

   assert_adj_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      adj_req |=> !adj_req);

   assert_adj_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      adj_req |-> carry_en);
endmodule

bind osc_ctrl_regs osc_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .wr_en(wr_en),
   .wr_addr(wr_addr), .rd_addr(rd_addr), .rd_data(rd_data),
   .busy_in(busy_in), .carry_en(carry_en), .test_n(test_n),
   .adj_req(adj_req), .halt_q(halt_q), .clen_q(clen_q),
   .gate_on(gate_on), .osc_rise(osc_rise), .clkout_lvl(clkout_lvl)
);

// File: tb/test_osc_ctrl_regs.sv
module test_osc_ctrl_regs;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 4;
   localparam logic [7:0] VEC [NVEC] = '{
      {4'b1011, 4'b1011},
      {4'b1111, 4'b1011},
      {4'b0010, 4'b0010},
      {4'b1010, 4'b1010}
   };

   logic clk = 0, rst_n = 0, osc_in = 0, chip_en = 0, wr_en = 0, busy_in = 0;
   logic [3:0] wr_addr = 0, wr_data = 0, rd_addr = 0;
   logic [3:0] rd_data;
   logic carry_en, adj_req, hour24, bank_sel, test_n, clkout_oe, clkout_lvl;
   logic osc_run = 1;
   int n_chk = 0, n_bad = 0, adj_cnt = 0;

   osc_ctrl_regs i_osc_ctrl_regs (
      .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .chip_en(chip_en),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .busy_in(busy_in),
      .carry_en(carry_en), .adj_req(adj_req), .hour24(hour24),
      .bank_sel(bank_sel), .test_n(test_n), .clkout_oe(clkout_oe),
      .clkout_lvl(clkout_lvl)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   initial forever begin
      repeat (8) @(negedge clk);
      if (osc_run) osc_in = ~osc_in;
   end

   always @(posedge clk) if (rst_n && adj_req) adj_cnt++;

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [3:0] d);
      @(negedge clk);
      wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [3:0] d);
      rd_addr = a; #1; d = rd_data;
   endtask

   task automatic oe_activity(output int hits);
      hits = 0;
      for (int i = 0; i < 32; i++) begin
         @(negedge clk);
         if (clkout_oe) hits++;
      end
   endtask

   task automatic finish_run;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      finish_run();
   end

   initial begin
      logic [3:0] d;
      int hits;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state
      rd(4'hE, d); check("R4 reset halt", d, 4'b0010);
      rd(4'hF, d); check("R2 reset ctrl2", d, 4'b0001);
      check("R3 reset carry_en", carry_en, 1);
      check("R8 level", clkout_lvl, 0);
      chip_en = 1;
      repeat (4) @(negedge clk);
      wr(4'hE, 4'b0010);
      rd(4'hE, d); check("R5 clear running", d, 4'b0000);

      // table of 0xF vectors
      for (int k = 0; k < NVEC; k++) begin
         wr(4'hF, VEC[k][7:4]);
         rd(4'hF, d); check("R2 ctrl2 vector", d, VEC[k][3:0]);
      end
      check("R2 hour24 pin", hour24, 1);
      check("R2 bank pin", bank_sel, 1);

      // R3 forced values
      wr(4'hE, 4'b0000);
      check("R3 carry written 0", carry_en, 0);
      @(negedge clk); chip_en = 0;
      repeat (3) @(negedge clk);
      check("R3 carry forced", carry_en, 1);
      check("R3 test forced", test_n, 1);
      // R10 write ignored while CE low
      wr(4'hF, 4'b0000);
      rd(4'hF, d); check("R10 write ignored", d, 4'b1011);
      chip_en = 1;
      @(negedge clk);

      // R9 adjust deferred
      adj_cnt = 0;
      wr(4'hE, 4'b0001);
      repeat (5) @(negedge clk);
      check("R9 deferred", adj_cnt, 0);
      wr(4'hE, 4'b0010);
      repeat (5) @(negedge clk);
      check("R9 released once", adj_cnt, 1);
      wr(4'hE, 4'b0011);
      repeat (5) @(negedge clk);
      check("R9 immediate once", adj_cnt, 2);

      // R1 busy
      busy_in = 1;
      rd(4'hE, d); check("R1 busy bit", d, 4'b0001);
      busy_in = 0;

      // R6 / R8 clock output
      rd(4'hA, d); check("R6 reset clen", d, 0);
      oe_activity(hits); check("R8 on at reset", hits > 0, 1);
      wr(4'hA, 4'b0001);
      rd(4'hA, d); check("R6 clen write", d, 1);
      repeat (48) @(negedge clk);
      oe_activity(hits); check("R8 disabled", hits, 0);
      wr(4'hA, 4'b0000);
      repeat (48) @(negedge clk);
      oe_activity(hits); check("R8 enabled", hits > 0, 1);

      // R6 bank 0 hides the bit
      wr(4'hF, 4'b1001);
      wr(4'hA, 4'b0001);
      rd(4'hA, d); check("R6 bank0 read", d, 0);
      wr(4'hF, 4'b1011);
      rd(4'hA, d); check("R6 bank0 write ignored", d, 0);

      // R4 / R7 halt behaviour
      wr(4'hA, 4'b0001);
      osc_run = 0;
      repeat (120) @(negedge clk);
      rd(4'hE, d); check("R4 held while CE high", d, 4'b0000);
      rd(4'hA, d); check("R6 clen kept", d, 1);
      chip_en = 0;
      repeat (10) @(negedge clk);
      chip_en = 1;
      @(negedge clk);
      rd(4'hE, d); check("R4 halt detected", d, 4'b0010);
      rd(4'hA, d); check("R7 clen forced", d, 0);
      wr(4'hE, 4'b0010);
      rd(4'hE, d); check("R5 no clear when stopped", d, 4'b0010);
      wr(4'hA, 4'b0001);
      rd(4'hA, d); check("R7 write ignored", d, 0);
      osc_run = 1;
      repeat (48) @(negedge clk);
      rd(4'hE, d); check("R5 sticky after restart", d, 4'b0010);
      oe_activity(hits); check("R7 output forced on", hits > 0, 1);
      wr(4'hE, 4'b0010);
      rd(4'hE, d); check("R5 clear after restart", d, 4'b0000);

      finish_run();
   end
endmodule